// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles every change of control flow while the instruction is still in the decode slot of a five-stage, 32-bit pipeline. It holds the fetch-to-decode pipeline register and looks at the instruction in it. For a conditional branch, it compares two register operands. When the register file copy of an operand is stale, the operand is taken from the result waiting at the end of the memory stage. It forms the branch target or the jump target and tells fetch which of three next-PC sources to use. Fetch always assumes the sequential path. When the decode decision overturns that assumption, the single wrong-path word that was fetched behind the branch is replaced by an all-zero no-op. A taken redirect therefore costs one bubble.

If a compare operand is still being produced by the instruction in execute, or by a load in the memory stage, the block raises a stall. While the stall is up it freezes its own decode register, makes no redirect and flushes nothing. The surrounding pipeline is expected to hold the PC and insert a bubble into execute.

Top module: `brj_decode_unit`

## Requirements
- R1: After reset the decode instruction word and PC+4 read zero, the next-PC select is sequential (0), and neither flush nor stall is asserted.
- R2: Instruction word fields are opcode [31:26], rs [25:21], rt [20:16], offset [15:0], jump index [25:0]. Opcode 0x04 is the equal branch, 0x05 the not-equal branch, 0x02 the jump. Any other opcode selects sequential, with next PC equal to the fetch-side PC+4 and no flush.
- R3: The branch target is the decode PC+4 plus the sign-extended offset multiplied by four.
- R4: The equal branch is taken when its two compare operands match and the not-equal branch when they differ. When not taken, the select is sequential and there is no flush.
- R5: A jump is always taken and never stalls. Its target is decode PC+4 bits [31:28], then the 26-bit index, then two zero bits.
- R6: The next-PC select reads 0 for sequential, 1 for branch target and 2 for jump target, and the next-PC output carries the chosen value in the same cycle.
- R7: Flush is raised exactly when a branch or jump is taken. At the following clock edge the decode instruction word becomes all zeros, a no-op that writes no register and no memory.
- R8: The rs operand is replaced by the memory-stage result when that stage writes a register that is nonzero and equals rs.
- R9: The rt operand is replaced by the memory-stage result under the same conditions with rt.
- R10: Register 0 is never replaced by the memory-stage result.
- R11: A branch whose rs or rt is nonzero and is written by the execute-stage instruction, or by a memory-stage load, raises stall. The select is then sequential, flush is low, and the decode register holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | 32 | Word fetched this cycle |
| fetch_pc4 | input | 32 | Fetch address plus four |
| rf_rs_val | input | 32 | Register file read of rs |
| rf_rt_val | input | 32 | Register file read of rt |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination register in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | ALU result held in the memory stage |
| id_instr | output | 32 | Instruction word now in decode |
| id_pc4 | output | 32 | PC+4 of the decode instruction |
| pc_sel | output | 2 | Next-PC source select |
| next_pc | output | 32 | Selected next fetch address |
| flush_if | output | 1 | Zero the word entering decode |
| stall_req | output | 1 | Operand not ready; hold PC and decode |

## Verification
Select, target, next PC, flush and stall all come from logic fed by the decode register. They are therefore due in the same cycle that an instruction lands in decode. The bench samples them one time unit after the loading edge. The effect of a flush or a stall only shows on the decode word at the next rising edge. Those checks present a fresh fetch word at the falling edge, wait one further edge and then read the decode outputs. Bypass and hazard inputs are also changed only at falling edges, so each combinational result is read after its inputs have settled.

// File: rtl/brj_pkg.sv
package brj_pkg;
  localparam logic [5:0] OP_BEQ = 6'h04;
  localparam logic [5:0] OP_BNE = 6'h05;
  localparam logic [5:0] OP_J   = 6'h02;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_JMP = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/brj_ifid_reg.sv
module brj_ifid_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            flush,
  input  logic [XLEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_pc4,
  output logic [XLEN-1:0] q_instr,
  output logic [XLEN-1:0] q_pc4
);
  logic            load_en;
  logic [XLEN-1:0] instr_d;

  always_comb begin
    load_en = !hold;
    instr_d = flush ? '0 : in_instr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_instr <= '0;
      q_pc4   <= '0;
    end else if (load_en) begin
      q_instr <= instr_d;
      q_pc4   <= in_pc4;
    end
  end

  // R7: a taken redirect leaves a zero word in decode
  a_r7_flush_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !hold) |=> (q_instr == '0));
  // R11: stall freezes the decode word
  a_r11_hold_decode: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q_instr));
endmodule

// File: rtl/brj_bypass.sv
module brj_bypass #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   src_idx,
  input  logic [XLEN-1:0] rf_val,
  input  logic [RW-1:0]   fwd_dst,
  input  logic            fwd_we,
  input  logic [XLEN-1:0] fwd_val,
  output logic [XLEN-1:0] opnd
);
  logic hit;

  always_comb begin
    hit  = fwd_we && (fwd_dst != '0) && (fwd_dst == src_idx);
    opnd = hit ? fwd_val : rf_val;
  end

  // R10: register zero always reads from the register file path
  a_r10_zero_not_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == '0) |-> (opnd == rf_val));
endmodule

// File: rtl/brj_target.sv
module brj_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc4,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] j_tgt
);
  localparam int OFFW = 16;
  localparam int IDXW = 26;
  localparam int HIW  = XLEN - IDXW - 2;

  logic [XLEN-1:0] off_scaled;

  always_comb begin
    off_scaled = {{(XLEN-OFFW-2){instr[OFFW-1]}}, instr[OFFW-1:0], 2'b00};
    br_tgt     = pc4 + off_scaled;
    j_tgt      = {pc4[XLEN-1 -: HIW], instr[IDXW-1:0], 2'b00};
  end
endmodule

// File: rtl/brj_resolve.sv
module brj_resolve
  import brj_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      opcode,
  input  logic [RW-1:0]   rs,
  input  logic [RW-1:0]   rt,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_we,
  input  logic [RW-1:0]   mem_dst,
  input  logic            mem_we,
  input  logic            mem_is_load,
  output npc_sel_e        sel,
  output logic            flush,
  output logic            stall
);
  logic is_br, is_j, ops_eq, take, ex_hz, ld_hz;

  always_comb begin
    is_br  = (opcode == OP_BEQ) || (opcode == OP_BNE);
    is_j   = (opcode == OP_J);
    ops_eq = (opa == opb);
    ex_hz  = ex_we && (ex_dst != '0) && ((ex_dst == rs) || (ex_dst == rt));
    ld_hz  = mem_is_load && mem_we && (mem_dst != '0) &&
             ((mem_dst == rs) || (mem_dst == rt));
    stall  = is_br && (ex_hz || ld_hz);
    take   = (opcode == OP_BEQ) ? ops_eq : !ops_eq;
    sel    = NPC_SEQ;
    if (is_j)                        sel = NPC_JMP;
    else if (is_br && !stall && take) sel = NPC_BR;
    flush  = (sel != NPC_SEQ);
  end

  // R11: no redirect and no flush while waiting on an operand
  a_r11_stall_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel == NPC_SEQ && !flush));
  // R5: a jump always redirects and never waits
  a_r5_jump_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_J) |-> (sel == NPC_JMP && flush && !stall));
endmodule

// File: rtl/brj_decode_unit.sv
module brj_decode_unit
  import brj_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] fetch_instr,
  input  logic [XLEN-1:0] fetch_pc4,
  input  logic [XLEN-1:0] rf_rs_val,
  input  logic [XLEN-1:0] rf_rt_val,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_we,
  input  logic [RW-1:0]   mem_dst,
  input  logic            mem_we,
  input  logic            mem_is_load,
  input  logic [XLEN-1:0] mem_result,
  output logic [XLEN-1:0] id_instr,
  output logic [XLEN-1:0] id_pc4,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc,
  output logic            flush_if,
  output logic            stall_req
);
  localparam int NOPS  = 2;
  localparam int RS_LO = XLEN - 6 - RW;
  localparam int RT_LO = RS_LO - RW;

  logic            rst_meta, rst_sync;
  logic [RW-1:0]   src_idx [NOPS];
  logic [XLEN-1:0] src_rf  [NOPS];
  logic [XLEN-1:0] src_op  [NOPS];
  logic [XLEN-1:0] br_tgt, j_tgt;
  npc_sel_e        sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  brj_ifid_reg #(.XLEN(XLEN)) u_ifid (
    .clk(clk), .rst_n(rst_sync), .hold(stall_req), .flush(flush_if),
    .in_instr(fetch_instr), .in_pc4(fetch_pc4),
    .q_instr(id_instr), .q_pc4(id_pc4)
  );

  always_comb begin
    src_idx[0] = id_instr[RS_LO +: RW];
    src_idx[1] = id_instr[RT_LO +: RW];
    src_rf[0]  = rf_rs_val;
    src_rf[1]  = rf_rt_val;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_byp
    brj_bypass #(.XLEN(XLEN), .RW(RW)) u_byp (
      .clk(clk), .rst_n(rst_sync),
      .src_idx(src_idx[g]), .rf_val(src_rf[g]),
      .fwd_dst(mem_dst), .fwd_we(mem_we), .fwd_val(mem_result),
      .opnd(src_op[g])
    );
  end

  brj_target #(.XLEN(XLEN)) u_tgt (
    .pc4(id_pc4), .instr(id_instr), .br_tgt(br_tgt), .j_tgt(j_tgt)
  );

  brj_resolve #(.XLEN(XLEN), .RW(RW)) u_res (
    .clk(clk), .rst_n(rst_sync),
    .opcode(id_instr[XLEN-1 -: 6]), .rs(src_idx[0]), .rt(src_idx[1]),
    .opa(src_op[0]), .opb(src_op[1]),
    .ex_dst(ex_dst), .ex_we(ex_we),
    .mem_dst(mem_dst), .mem_we(mem_we), .mem_is_load(mem_is_load),
    .sel(sel), .flush(flush_if), .stall(stall_req)
  );

  always_comb begin
    pc_sel = sel;
    unique case (sel)
      NPC_BR:  next_pc = br_tgt;
      NPC_JMP: next_pc = j_tgt;
      default: next_pc = fetch_pc4;
    endcase
  end

  // R6: the selected source reaches next_pc
  a_r6_seq_passes_fetch: assert property (@(posedge clk) disable iff (!rst_sync)
    (pc_sel == 2'd0) |-> (next_pc == fetch_pc4 && !flush_if));
endmodule

// File: tb/tb_brj_decode_unit.sv
module tb_brj_decode_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_instr, fetch_pc4, rf_rs_val, rf_rt_val, mem_result;
  logic [4:0]  ex_dst, mem_dst;
  logic        ex_we, mem_we, mem_is_load;
  logic [31:0] id_instr, id_pc4, next_pc;
  logic [1:0]  pc_sel;
  logic        flush_if, stall_req;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  brj_decode_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .fetch_pc4(fetch_pc4),
    .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val), .ex_dst(ex_dst), .ex_we(ex_we),
    .mem_dst(mem_dst), .mem_we(mem_we), .mem_is_load(mem_is_load),
    .mem_result(mem_result), .id_instr(id_instr), .id_pc4(id_pc4),
    .pc_sel(pc_sel), .next_pc(next_pc), .flush_if(flush_if), .stall_req(stall_req)
  );

  localparam logic [31:0] ADD_W = 32'h0085_1820;

  function automatic logic [31:0] enc_br(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] off);
    return {op, rs, rt, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    ex_we = 0; ex_dst = 0; mem_we = 0; mem_dst = 0; mem_is_load = 0;
    mem_result = 0; rf_rs_val = 0; rf_rt_val = 0;
  endtask

  // places word w in decode; outputs are sampled 1 ns after the edge
  task automatic put(input logic [31:0] w, input logic [31:0] pc4);
    @(negedge clk);
    fetch_instr = 32'h0; fetch_pc4 = 32'h0;
    @(posedge clk);
    @(negedge clk);
    fetch_instr = w; fetch_pc4 = pc4;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 instr", id_instr, 0);
    chk("R1 pc4", id_pc4, 0);
    chk("R1 sel", {30'd0, pc_sel}, 0);
    chk("R1 flush/stall", {30'd0, flush_if, stall_req}, 0);
  endtask

  task automatic t_plain();
    quiet();
    put(ADD_W, 32'h100);
    fetch_pc4 = 32'h104; #1;
    chk("R2 sel", {30'd0, pc_sel}, 0);
    chk("R2 next", next_pc, 32'h104);
    chk("R2 flush", {31'd0, flush_if}, 0);
  endtask

  task automatic t_beq();
    quiet();
    rf_rs_val = 32'd9; rf_rt_val = 32'd9;
    put(enc_br(6'h04, 5'd1, 5'd2, 16'h0010), 32'h0000_2000);
    chk("R4 beq eq sel", {30'd0, pc_sel}, 1);
    chk("R3 fwd target", next_pc, 32'h0000_2040);
    chk("R7 flush", {31'd0, flush_if}, 1);
    @(negedge clk); fetch_instr = ADD_W;
    @(posedge clk); #1;
    chk("R7 bubble", id_instr, 0);
    quiet();
    rf_rs_val = 32'd9; rf_rt_val = 32'd8;
    put(enc_br(6'h04, 5'd1, 5'd2, 16'h0010), 32'h0000_2000);
    chk("R4 beq ne sel", {30'd0, pc_sel}, 0);
    chk("R4 beq ne flush", {31'd0, flush_if}, 0);
  endtask

  task automatic t_bne_back();
    quiet();
    rf_rs_val = 32'd1; rf_rt_val = 32'd2;
    put(enc_br(6'h05, 5'd3, 5'd4, 16'hFFFC), 32'h0000_3000);
    chk("R4 bne taken", {30'd0, pc_sel}, 1);
    chk("R3 back target", next_pc, 32'h0000_2FF0);
    rf_rt_val = 32'd1; #1;
    chk("R4 bne eq not taken", {30'd0, pc_sel}, 0);
  endtask

  task automatic t_jump();
    quiet();
    ex_we = 1; ex_dst = 5'd7;
    put({6'h02, 26'h123_4567}, 32'hA000_0010);
    chk("R6 jump sel", {30'd0, pc_sel}, 2);
    chk("R5 jump target", next_pc, {4'hA, 26'h123_4567, 2'b00});
    chk("R5 no stall", {31'd0, stall_req}, 0);
    @(negedge clk); fetch_instr = ADD_W;
    @(posedge clk); #1;
    chk("R7 jump bubble", id_instr, 0);
  endtask

  task automatic t_bypass();
    quiet();
    rf_rs_val = 32'd5; rf_rt_val = 32'd6;
    mem_we = 1; mem_dst = 5'd3; mem_result = 32'd6;
    put(enc_br(6'h04, 5'd3, 5'd4, 16'h0001), 32'h40);
    chk("R8 rs bypass", {30'd0, pc_sel}, 1);
    mem_dst = 5'd4; mem_result = 32'd5; #1;
    chk("R9 rt bypass", {30'd0, pc_sel}, 1);
    mem_we = 0; #1;
    chk("R8 no bypass when no write", {30'd0, pc_sel}, 0);
    quiet();
    rf_rs_val = 32'd0; rf_rt_val = 32'd7;
    mem_we = 1; mem_dst = 5'd0; mem_result = 32'd7;
    put(enc_br(6'h05, 5'd0, 5'd5, 16'h0001), 32'h40);
    chk("R10 zero reg", {30'd0, pc_sel}, 1);
  endtask

  task automatic t_stall();
    quiet();
    ex_we = 1; ex_dst = 5'd2; rf_rs_val = 1; rf_rt_val = 1;
    put(enc_br(6'h04, 5'd1, 5'd2, 16'h0004), 32'h80);
    chk("R11 ex stall", {31'd0, stall_req}, 1);
    chk("R11 sel seq", {30'd0, pc_sel}, 0);
    chk("R11 no flush", {31'd0, flush_if}, 0);
    @(negedge clk); fetch_instr = ADD_W;
    @(posedge clk); #1;
    chk("R11 hold", id_instr, enc_br(6'h04, 5'd1, 5'd2, 16'h0004));
    @(negedge clk); ex_we = 0; #1;
    chk("R11 released", {30'd0, pc_sel}, 1);
    quiet();
    mem_we = 1; mem_is_load = 1; mem_dst = 5'd1;
    put(enc_br(6'h05, 5'd1, 5'd2, 16'h0004), 32'h80);
    chk("R11 load stall", {31'd0, stall_req}, 1);
    mem_is_load = 0; #1;
    chk("R11 alu result bypassed not stalled", {31'd0, stall_req}, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; fetch_instr = 0; fetch_pc4 = 0;
    ex_we = 0; ex_dst = 0; mem_we = 0; mem_dst = 0; mem_is_load = 0;
    mem_result = 0; rf_rs_val = 0; rf_rt_val = 0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    t_plain();
    t_beq();
    t_bne_back();
    t_jump();
    t_bypass();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule